// File: doc/BRIEF.md
# Timing-Jitter Seed Harvester

This block produces seeds for a pseudo-random generator from timing uncertainty. It counts cycles of its own clock, which is taken to be a fast on-chip oscillator with a poorly controlled frequency. The count runs until an asynchronous event arrives. The event source depends on the mode. In one mode it is a slow external reference clock, and the count ends on a fixed number of its rising edges, which divides the reference down. In the other mode it is an RC node on a pin. The block pulls the node low for a while, then lets it go, and the count ends when the pin is seen to rise.

Each harvest is started by a pulse on `start_i`. When the event arrives, the count is latched in a capture register. Its low bits, with the least significant bit forced to one, are loaded into a Galois LFSR. That LFSR's state is the block's random output.

In RC mode the node is not fully drained between harvests. The time it is held low is taken from the low bits of the previous capture, which feeds the last result back into the next measurement. If no event arrives within the count range, the block raises a timeout flag and delivers no seed.

Top module: `jitter_seed_harvester`

## Requirements
- R1: After reset these outputs are all zero: `busy_o`, `rc_drive_low_o`, `seed_valid_o`, `timeout_o`, `cap_count_o`, `seed_o` and `rnd_o`.
- R2: An RC-mode harvest (`mode_i`=1) holds `rc_drive_low_o` high for exactly (cap[2:0]+1)*8 consecutive cycles. Here cap is the `cap_count_o` value from before the start, and it is zero after reset.
- R3: In RC mode the count starts at 0 in the cycle that follows the release, when `rc_drive_low_o` falls. It stops on the first rising edge of `rc_pin_i` after two-flop synchronization. If the pin is driven high d cycles after release, `cap_count_o` lands in d+1..d+3.
- R4: In reference mode (`mode_i`=0) the count starts right after the start. It stops on the REF_DIV-th (default 4) synchronized rising edge of `ref_clk_i`. Fewer edges than that do not end the harvest.
- R5: `seed_o` equals `cap_count_o` bits [15:1] with bit 0 forced to 1.
- R6: `seed_valid_o` is a single-cycle pulse for each completed harvest. In that cycle `rnd_o` equals `seed_o`.
- R7: After the load, `rnd_o` advances by one Galois right-shift step every cycle. Each step is next = (s>>1) ^ (s[0] ? 16'hB400 : 0).
- R8: If 2^16 cycles of counting pass with no event, `timeout_o` goes high, no seed pulse is given and `busy_o` drops. The next start clears `timeout_o`.
- R9: A `start_i` pulse while `busy_o` is high has no effect on the harvest in progress. This covers both its mode and its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast free-running oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a harvest (accepted when idle) |
| mode_i | input | 1 | 1 = RC pin timing, 0 = reference clock edges |
| ref_clk_i | input | 1 | Slow asynchronous reference clock |
| rc_pin_i | input | 1 | Level read back from the RC node |
| rc_drive_low_o | output | 1 | 1 = pull RC node low, 0 = release (tristate) |
| busy_o | output | 1 | Harvest in progress |
| seed_valid_o | output | 1 | One-cycle pulse when a new seed is loaded |
| timeout_o | output | 1 | Last harvest ended without an event |
| cap_count_o | output | 16 | Captured raw count |
| seed_o | output | 16 | Seed loaded into the generator |
| rnd_o | output | 16 | Pseudo-random generator state |

## Verification
The assertions assume some things about the inputs. They take `start_i` to be a clean synchronous pulse. They allow `ref_clk_i` and `rc_pin_i` to change at any time, because they check only what follows the synchronizer: the seed and capture relationship, the pulse width, and the generator step.

The bench drives every asynchronous input away from the clock edge. It also keeps reference pulses at least one cycle wide, so that no edge can be lost in the synchronizer. This lets the expected count be bounded to a narrow window.

// File: rtl/jsh_pkg.sv
package jsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DISCH = 2'd1,
    ST_COUNT = 2'd2
  } jsh_state_e;
endpackage

// File: rtl/jsh_sync.sv
module jsh_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/jsh_pn_gen.sv
module jsh_pn_gen #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lfsr_q <= '0;
    else if (load_i)      lfsr_q <= seed_i;
    else if (lfsr_q[0])   lfsr_q <= (lfsr_q >> 1) ^ TAPS;
    else                  lfsr_q <= lfsr_q >> 1;
  end

  assign state_o = lfsr_q;
endmodule

// File: rtl/jsh_ctrl.sv
module jsh_ctrl
  import jsh_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int REF_DIV       = 4,
  parameter int DIS_SEL_W     = 3,
  parameter int DIS_UNIT_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             ref_s_i,
  input  logic             pin_s_i,
  output logic             drive_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic [CNT_W-1:0] cap_o
);
  localparam int DIS_W  = DIS_SEL_W + DIS_UNIT_LOG2 + 1;
  localparam int EDGE_W = $clog2(REF_DIV + 1);

  jsh_state_e        state_q;
  logic              mode_q, ref_d_q, pin_d_q, done_q, to_q;
  logic [CNT_W-1:0]  cnt_q, cap_q;
  logic [DIS_W-1:0]  dis_q, dis_load;
  logic [EDGE_W-1:0] edge_q;
  logic              ref_rise, pin_rise, hit;

  assign ref_rise = ref_s_i & ~ref_d_q;
  assign pin_rise = pin_s_i & ~pin_d_q;
  // discharge length picked from low bits of the previous capture
  assign dis_load = (DIS_W'(cap_q[DIS_SEL_W-1:0]) + DIS_W'(1)) << DIS_UNIT_LOG2;
  assign hit = mode_q ? pin_rise : (ref_rise && (edge_q == EDGE_W'(REF_DIV - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      ref_d_q <= 1'b0;
      pin_d_q <= 1'b0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      cnt_q   <= '0;
      cap_q   <= '0;
      dis_q   <= '0;
      edge_q  <= '0;
    end else begin
      ref_d_q <= ref_s_i;
      pin_d_q <= pin_s_i;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          to_q   <= 1'b0;
          mode_q <= mode_i;
          cnt_q  <= '0;
          edge_q <= '0;
          if (mode_i) begin
            dis_q   <= dis_load;
            state_q <= ST_DISCH;
          end else begin
            state_q <= ST_COUNT;
          end
        end
        ST_DISCH: begin
          if (dis_q == DIS_W'(1)) begin
            cnt_q   <= '0;
            state_q <= ST_COUNT;
          end else begin
            dis_q <= dis_q - DIS_W'(1);
          end
        end
        ST_COUNT: begin
          if (hit) begin
            cap_q   <= cnt_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (&cnt_q) begin
            to_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (ref_rise) edge_q <= edge_q + EDGE_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_low_o = (state_q == ST_DISCH);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = to_q;
  assign cap_o       = cap_q;
endmodule

// File: rtl/jitter_seed_harvester.sv
module jitter_seed_harvester #(
  parameter int                 SEED_W        = 16,
  parameter int                 CNT_W         = 16,
  parameter int                 REF_DIV       = 4,
  parameter int                 DIS_SEL_W     = 3,
  parameter int                 DIS_UNIT_LOG2 = 3,
  parameter logic [SEED_W-1:0]  PN_TAPS       = 16'hB400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              ref_clk_i,
  input  logic              rc_pin_i,
  output logic              rc_drive_low_o,
  output logic              busy_o,
  output logic              seed_valid_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  cap_count_o,
  output logic [SEED_W-1:0] seed_o,
  output logic [SEED_W-1:0] rnd_o
);
  localparam int N_ASYNC = 2;

  logic [N_ASYNC-1:0] async_raw, async_s;
  logic               done;
  logic [CNT_W-1:0]   cap;
  logic [SEED_W-1:0]  seed_next, seed_q;
  logic               valid_q;

  assign async_raw = {rc_pin_i, ref_clk_i};

  jsh_sync #(.W(N_ASYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_raw),
    .q_o   (async_s)
  );

  jsh_ctrl #(
    .CNT_W        (CNT_W),
    .REF_DIV      (REF_DIV),
    .DIS_SEL_W    (DIS_SEL_W),
    .DIS_UNIT_LOG2(DIS_UNIT_LOG2)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .ref_s_i    (async_s[0]),
    .pin_s_i    (async_s[1]),
    .drive_low_o(rc_drive_low_o),
    .busy_o     (busy_o),
    .done_o     (done),
    .timeout_o  (timeout_o),
    .cap_o      (cap)
  );

  // odd seed keeps the generator out of the all-zero state
  assign seed_next = {cap[SEED_W-1:1], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done;
      if (done) seed_q <= seed_next;
    end
  end

  jsh_pn_gen #(.W(SEED_W), .TAPS(PN_TAPS)) u_pn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (done),
    .seed_i (seed_next),
    .state_o(rnd_o)
  );

  assign seed_valid_o = valid_q;
  assign seed_o       = seed_q;
  assign cap_count_o  = cap;
endmodule

// File: rtl/jitter_seed_harvester_chk.sv
module jitter_seed_harvester_chk #(
  parameter int                SEED_W  = 16,
  parameter int                CNT_W   = 16,
  parameter logic [SEED_W-1:0] PN_TAPS = 16'hB400
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rc_drive_low_o,
  input logic              busy_o,
  input logic              seed_valid_o,
  input logic              timeout_o,
  input logic [CNT_W-1:0]  cap_count_o,
  input logic [SEED_W-1:0] seed_o,
  input logic [SEED_W-1:0] rnd_o
);
  p_drive_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_drive_low_o |-> busy_o);

  p_seed_odd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o |-> seed_o[0]);

  p_seed_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o |-> (seed_o[SEED_W-1:1] == cap_count_o[SEED_W-1:1]));

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o |=> !seed_valid_o);

  p_rnd_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o |-> (rnd_o == seed_o));

  p_pn_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_valid_o |-> (rnd_o == (($past(rnd_o) >> 1) ^ ($past(rnd_o[0]) ? PN_TAPS : '0))));

  p_timeout_no_seed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!seed_valid_o && !busy_o));
endmodule

bind jitter_seed_harvester jitter_seed_harvester_chk #(
  .SEED_W (SEED_W),
  .CNT_W  (CNT_W),
  .PN_TAPS(PN_TAPS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rc_drive_low_o(rc_drive_low_o),
  .busy_o        (busy_o),
  .seed_valid_o  (seed_valid_o),
  .timeout_o     (timeout_o),
  .cap_count_o   (cap_count_o),
  .seed_o        (seed_o),
  .rnd_o         (rnd_o)
);

// File: tb/jitter_seed_harvester_bench.sv
`timescale 1ns/1ps
module jitter_seed_harvester_bench;
  localparam int REF_DIV = 4;
  localparam logic [15:0] TAPS = 16'hB400;
  localparam int NV = 6;
  // mode 1 = RC (param = release-to-high delay), mode 0 = reference (param = period)
  localparam int VEC_MODE [NV] = '{1, 1, 0, 1, 0, 1};
  localparam int VEC_P    [NV] = '{5, 20, 4, 2, 10, 40};

  logic clk = 0, rst_n = 0;
  logic start = 0, mode = 0, ref_clk = 0, pin = 1;
  logic drive_low, busy, valid, tout;
  logic [15:0] cap, seed, rnd;
  int errs = 0, checks = 0;
  int prev_cap = 0;

  always #5 clk = ~clk;

  jitter_seed_harvester u_jitter_seed_harvester (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .ref_clk_i(ref_clk), .rc_pin_i(pin), .rc_drive_low_o(drive_low),
    .busy_o(busy), .seed_valid_o(valid), .timeout_o(tout),
    .cap_count_o(cap), .seed_o(seed), .rnd_o(rnd)
  );

  function automatic logic [15:0] step(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_seed(input int lo, input int hi, input string req);
    logic [15:0] s;
    chk(cap >= lo && cap <= hi, req, cap, lo);
    chk(seed == {cap[15:1], 1'b1}, "R5 seed", seed, {cap[15:1], 1'b1});
    chk(rnd == seed, "R6 load", rnd, seed);
    s = seed;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      s = step(s);
      chk(rnd == s, "R7 step", rnd, s);
    end
    prev_cap = cap;
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 400 && !got; i++) begin
      if (valid) got = 1;
      else @(negedge clk);
    end
  endtask

  task automatic run_rc(input int d, input bit poke);
    int n, exp_dis;
    bit got;
    exp_dis = ((prev_cap & 7) + 1) * 8;
    @(negedge clk); start = 1; mode = 1;
    @(negedge clk); start = 0;
    chk(tout == 0, "R8 clear", tout, 0);
    n = 0;
    while (drive_low && n < 200) begin pin = 0; n++; @(negedge clk); end
    chk(n == exp_dis, "R2 discharge", n, exp_dis);
    for (int k = 0; k < d; k++) begin
      if (poke && k == 0) begin start = 1; mode = 0; end
      @(negedge clk);
      if (poke && k == 0) begin
        start = 0;
        chk(drive_low == 0 && busy == 1, "R9 busy start", drive_low, 0);
      end
    end
    pin = 1;
    wait_valid(got);
    chk(got, "R3 rc seed", got, 1);
    if (got) check_seed(d + 1, d + 3, "R3 rc count");
  endtask

  task automatic run_ref(input int t, input int edges, output bit got);
    int k;
    got = 0;
    @(negedge clk); start = 1; mode = 0;
    @(negedge clk); start = 0;
    chk(tout == 0, "R8 clear", tout, 0);
    k = 0;
    while (!got && k < 2 + edges * t + 30) begin
      ref_clk = (k >= 2) && ((k - 2) / t < edges) && (((k - 2) % t) < t / 2);
      if (valid) got = 1;
      else begin @(negedge clk); k++; end
    end
    ref_clk = 0;
  endtask

  initial begin
    bit got;
    int n, nv, exp_c, old_cap;
    #1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !drive_low && !valid && !tout, "R1 ctrl", {busy, drive_low, valid, tout}, 0);
    chk(cap == 0 && seed == 0 && rnd == 0, "R1 data", cap | seed | rnd, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC_MODE[v] == 1) run_rc(VEC_P[v], 1'b0);
      else begin
        run_ref(VEC_P[v], REF_DIV, got);
        chk(got, "R4 ref seed", got, 1);
        exp_c = 2 + (REF_DIV - 1) * VEC_P[v] + 2;
        if (got) check_seed(exp_c - 1, exp_c + 1, "R4 ref count");
      end
      repeat (4) @(negedge clk);
    end

    // R9: start pulse while counting is ignored
    run_rc(12, 1'b1);
    repeat (4) @(negedge clk);

    // R4/R8: too few reference edges -> no seed, timeout
    old_cap = cap;
    run_ref(6, REF_DIV - 1, got);
    chk(!got, "R4 few edges", got, 0);
    n = 0; nv = 0;
    while (busy && n < 70000) begin
      if (valid) nv++;
      @(negedge clk); n++;
    end
    chk(tout == 1, "R8 timeout flag", tout, 1);
    chk(nv == 0 && !valid, "R8 no seed", nv, 0);
    chk(n > 65000, "R8 window", n, 65000);
    chk(cap == old_cap, "R8 cap kept", cap, old_cap);

    // R8 clear on next start, R2 discharge after timeout
    run_rc(7, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule